// File: doc/BRIEF.md
# Two-Button Stopwatch Run/Clear Controller

This block converts two already-synchronized push buttons into the two level controls a stopwatch time counter needs: a run enable and a clear request. Button bit 1 is the start/stop button: one press starts the watch and the next press stops it. Button bit 0 is the clear button: while the watch is stopped and idle, holding it raises the clear request for as long as it is held.

The controller is a five-state Moore machine. Every button action waits for the button to be released before the next action can happen, so a long press toggles the watch exactly once. The clear request can be raised only from the idle stopped state. Outside that state the clear button is ignored. Both outputs are driven by flip-flops and depend on the state alone, so they never follow button changes combinationally.

Top module: `chrono_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs are 0 after that edge, whatever the buttons are. The controller then restarts in its idle stopped state.
- R2: In idle, the combination `btn[0]`=1, `btn[1]`=0 gives `clr_req`=1 and `run_en`=0 after the next edge.
- R3: `clr_req` stays 1 while `btn[0]` is held. The first edge that sees `btn[0]`=0 returns the controller to idle, and both outputs become 0.
- R4: In idle, the combination `btn[1]`=1, `btn[0]`=0 enters a stopped wait-for-release state. Both outputs stay 0 while `btn[1]` is held.
- R5: From that stopped wait state, the first edge that sees `btn[1]`=0 sets `run_en`=1. This is the running state.
- R6: In the running state, pressing `btn[1]` keeps `run_en`=1 for as long as it is held. The edge that sees the release clears `run_en` and returns to idle, so a held press stops the watch exactly once.
- R7: `btn[0]` has no effect in any state other than idle. It never raises `clr_req` and never changes `run_en` there.
- R8: In idle, pressing both buttons together leaves the controller in idle, with both outputs 0.
- R9: `run_en` and `clr_req` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 2 | Buttons, 1 = pressed. Bit 0 is clear, bit 1 is start/stop |
| run_en | output | 1 | Registered run enable for the time counter |
| clr_req | output | 1 | Registered clear request for the time counter |

## Verification
Every output change is due exactly one rising edge after the button value that causes it. The state and the output flops update on the same edge, and there is no further register stage. The bench changes `btn` on the falling edge and then reads both outputs at the following falling edge. Each check therefore sees the effect of exactly one edge. Held-button checks repeat the same input over several edges to confirm that nothing changes until the release is seen.

// File: rtl/chrono_pkg.sv
package chrono_pkg;

  // Controller states; encoding is free, only the output decode matters.
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLEAR    = 3'd1,
    ST_ARM_WAIT = 3'd2,
    ST_RUN      = 3'd3,
    ST_HALT_WAIT= 3'd4
  } chrono_state_e;

  typedef struct packed {
    logic clr;
    logic run;
  } chrono_out_t;

  // Moore output of each state.
  function automatic chrono_out_t decode_out(chrono_state_e s);
    chrono_out_t o;
    o = '{clr: 1'b0, run: 1'b0};
    case (s)
      ST_CLEAR:     o.clr = 1'b1;
      ST_RUN:       o.run = 1'b1;
      ST_HALT_WAIT: o.run = 1'b1;
      default:      o = '{clr: 1'b0, run: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/chrono_next.sv
module chrono_next
  import chrono_pkg::*;
#(
  parameter int BTN_W   = 2,
  parameter int CLR_BIT = 0,
  parameter int TGL_BIT = 1
) (
  input  chrono_state_e    cur,
  input  logic [BTN_W-1:0] btn,
  output chrono_state_e    nxt
);

  logic clr_b, tgl_b;
  assign clr_b = btn[CLR_BIT];
  assign tgl_b = btn[TGL_BIT];

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: begin
        if (clr_b && !tgl_b)      nxt = ST_CLEAR;
        else if (tgl_b && !clr_b) nxt = ST_ARM_WAIT;
      end
      ST_CLEAR:     if (!clr_b) nxt = ST_IDLE;
      ST_ARM_WAIT:  if (!tgl_b) nxt = ST_RUN;
      ST_RUN:       if (tgl_b)  nxt = ST_HALT_WAIT;
      ST_HALT_WAIT: if (!tgl_b) nxt = ST_IDLE;
      default:                  nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/chrono_state_reg.sv
module chrono_state_reg
  import chrono_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  chrono_state_e nxt,
  output chrono_state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

endmodule

// File: rtl/chrono_out_stage.sv
module chrono_out_stage
  import chrono_pkg::*;
#(
  parameter bit OUT_FROM_NEXT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  chrono_state_e cur,
  input  chrono_state_e nxt,
  output logic          run_o,
  output logic          clr_o
);

  generate
    if (OUT_FROM_NEXT) begin : g_flop
      // Outputs held in their own flops, loaded with the decode of the next state.
      chrono_out_t out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '{clr: 1'b0, run: 1'b0};
        else     out_q <= decode_out(nxt);
      end
      assign run_o = out_q.run;
      assign clr_o = out_q.clr;
    end else begin : g_decode
      // Outputs decoded from the state register only.
      chrono_out_t out_c;
      assign out_c = decode_out(cur);
      assign run_o = out_c.run;
      assign clr_o = out_c.clr;
    end
  endgenerate

endmodule

// File: rtl/chrono_ctrl.sv
module chrono_ctrl
  import chrono_pkg::*;
#(
  parameter int BTN_W         = 2,
  parameter int CLR_BIT       = 0,
  parameter int TGL_BIT       = 1,
  parameter bit OUT_FROM_NEXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_W-1:0] btn,
  output logic             run_en,
  output logic             clr_req
);

  chrono_state_e state_q, state_d;

  chrono_next #(.BTN_W(BTN_W), .CLR_BIT(CLR_BIT), .TGL_BIT(TGL_BIT)) u_next (
    .cur(state_q), .btn(btn), .nxt(state_d)
  );

  chrono_state_reg u_state (
    .clk(clk), .rst(rst), .nxt(state_d), .cur(state_q)
  );

  chrono_out_stage #(.OUT_FROM_NEXT(OUT_FROM_NEXT)) u_out (
    .clk(clk), .rst(rst), .cur(state_q), .nxt(state_d),
    .run_o(run_en), .clr_o(clr_req)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!run_en && !clr_req));

  p_clear_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && btn[CLR_BIT] && !btn[TGL_BIT]) |=> (clr_req && !run_en));

  p_clear_release_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !btn[CLR_BIT]) |=> (!clr_req && !run_en));

  p_arm_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM_WAIT && btn[TGL_BIT]) |=> (!run_en && !clr_req));

  p_arm_release_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM_WAIT && !btn[TGL_BIT]) |=> run_en);

  p_run_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (run_en && btn[TGL_BIT]) |=> run_en);

  p_clear_inert_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q != ST_CLEAR) |=> !clr_req);

  p_both_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && btn[CLR_BIT] && btn[TGL_BIT]) |=> (state_q == ST_IDLE));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(run_en && clr_req));

endmodule

// File: tb/chrono_ctrl_test.sv
module chrono_ctrl_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] btn = 2'b00;
  logic       run_en, clr_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  chrono_ctrl uut (.clk(clk), .rst(rst), .btn(btn), .run_en(run_en), .clr_req(clr_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Drive at a falling edge; return at the next falling edge (one rising edge later).
  task automatic apply(input logic [1:0] b);
    btn = b;
    @(negedge clk);
  endtask

  task automatic check(input logic exp_run, input logic exp_clr, input string req);
    n_checks++;
    if (run_en !== exp_run || clr_req !== exp_clr) begin
      n_fail++;
      $display("FAIL %s: run_en/clr_req = %b/%b, expected %b/%b",
               req, run_en, clr_req, exp_run, exp_clr);
    end
    n_checks++;
    if (run_en === 1'b1 && clr_req === 1'b1) begin
      n_fail++;
      $display("FAIL R9: run_en/clr_req = 1/1, expected not both 1");
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; btn = 2'b10;
    @(negedge clk); @(negedge clk);
    check(1'b0, 1'b0, "R1");
    rst = 1'b0; apply(2'b00);
    check(1'b0, 1'b0, "R1");
  endtask

  task automatic t_clear;
    apply(2'b01); check(1'b0, 1'b1, "R2");
    for (int i = 0; i < 3; i++) begin apply(2'b01); check(1'b0, 1'b1, "R3"); end
    apply(2'b00); check(1'b0, 1'b0, "R3");
  endtask

  task automatic t_start;
    apply(2'b10); check(1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) begin apply(2'b10); check(1'b0, 1'b0, "R4"); end
    apply(2'b00); check(1'b1, 1'b0, "R5");
    apply(2'b00); check(1'b1, 1'b0, "R5");
  endtask

  task automatic t_stop;
    for (int i = 0; i < 4; i++) begin apply(2'b10); check(1'b1, 1'b0, "R6"); end
    apply(2'b00); check(1'b0, 1'b0, "R6");
    apply(2'b00); check(1'b0, 1'b0, "R6");
  endtask

  task automatic t_clear_inert;
    t_start();
    for (int i = 0; i < 3; i++) begin apply(2'b01); check(1'b1, 1'b0, "R7"); end
    apply(2'b00); check(1'b1, 1'b0, "R7");
    t_stop();
    // clear button pressed during the stopped wait-for-release state
    apply(2'b10); check(1'b0, 1'b0, "R7");
    apply(2'b11); check(1'b0, 1'b0, "R7");
    apply(2'b01); check(1'b1, 1'b0, "R7");
    apply(2'b00); check(1'b1, 1'b0, "R7");
    t_stop();
  endtask

  task automatic t_both;
    for (int i = 0; i < 3; i++) begin apply(2'b11); check(1'b0, 1'b0, "R8"); end
    apply(2'b00); check(1'b0, 1'b0, "R8");
    apply(2'b01); check(1'b0, 1'b1, "R8");
    apply(2'b00); check(1'b0, 1'b0, "R8");
  endtask

  task automatic t_reset_running;
    t_start();
    rst = 1'b1; btn = 2'b11;
    @(negedge clk);
    check(1'b0, 1'b0, "R1");
    rst = 1'b0; apply(2'b00); check(1'b0, 1'b0, "R1");
    apply(2'b01); check(1'b0, 1'b1, "R1");
    apply(2'b00); check(1'b0, 1'b0, "R1");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_clear();
    t_start();
    t_stop();
    t_clear_inert();
    t_both();
    t_reset_running();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

endmodule